// File: doc/BRIEF.md
# Dual-Channel Compare Timer Register File

This block keeps one free-running 64-bit system counter and two compare channels, a physical one (channel 0) and a virtual one (channel 1). Both channels compare against the same counter. A channel holds a 64-bit absolute compare point and a two-bit control word (enable and interrupt mask). A read-only status bit reports that the compare point has been reached. A channel raises its interrupt output while its status is set and its mask is clear. Software can also see each compare point as a 32-bit signed down-count relative to the present counter value, and can set it that way.

Software reaches the block through a plain synchronous register port: a 4-bit register select, read and write strobes, 64-bit write data and a 2-bit privilege level, where 0 means unprivileged. Each access is answered in the clock cycle after its strobe with read data and an access-fault flag. An unprivileged access is allowed only for the registers that a kernel-control register opens to it. A read-as-written frequency register reports the nominal counting rate to software.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both control words, both compare points and the kernel-control register read 0, the frequency register reads 1e9/PRESCALE, and both interrupt outputs are low.
- R2: The counter rises by one every PRESCALE clocks after reset is released and wraps modulo 2^64. Selects 2 and 3 both return the counter value sampled in the strobe cycle.
- R3: A control write (select 4 physical, 7 virtual) keeps only wrData[1:0], with bit 0 = enable and bit 1 = mask. A control read returns enable in bit 0, mask in bit 1, status in bit 2 and zeros above. The status bit cannot be written.
- R4: While a channel is enabled, its status is 1 exactly when counter >= compare point, compared as unsigned 64-bit values. The compare point is at select 5 (physical) or 8 (virtual).
- R5: A channel's interrupt output equals status AND NOT mask. While the channel is disabled, its status reads 0 and its interrupt stays low.
- R6: A down-count read (select 6 physical, 9 virtual) returns the low 32 bits of (compare point - counter), zero-extended to 64 bits.
- R7: A down-count write sets the compare point to the counter plus the sign-extended wrData[31:0]. wrData[63:32] is ignored.
- R8: The frequency register (select 0) stores what is written and reads it back. Writing it leaves the counting rate unchanged.
- R9: At privilege 0, a counter read at select 2 needs kernel-control bit 0 and one at select 3 needs kernel-control bit 1. Otherwise the access faults.
- R10: At privilege 0, any access to physical-channel registers (selects 4-6) needs kernel-control bit 9, and any access to virtual-channel registers (selects 7-9) needs bit 8. Otherwise the access faults.
- R11: At privilege 0, a frequency read needs kernel-control bit 0 or bit 1, and a frequency write always faults. The kernel-control register (select 1) faults on any access at privilege 0.
- R12: A faulting access raises accFault for the one response cycle, returns rdData of 0 and changes no register.
- R13: rdData and accFault answer an access one clock after the strobe. Selects 10-15 read 0 without a fault and ignore writes. Writes to the counter selects are ignored. If both strobes are set, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regSel | input | 4 | Register select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Write data |
| privLvl | input | 2 | Privilege level of the access, 0 = unprivileged |
| rdData | output | 64 | Read data, valid the cycle after a read strobe |
| accFault | output | 1 | Access fault, valid the cycle after a strobe |
| irqPhys | output | 1 | Physical channel interrupt |
| irqVirt | output | 1 | Virtual channel interrupt |

## Verification
The assertions assume that the strobes, select, data and privilege are stable around each rising edge and that reset is applied from time zero. They also assume that a fault can only follow an access made at privilege 0. The directed bench drives every access just after a falling edge and holds it for exactly one rising edge. It keeps its own count of edges since reset release to predict the counter, so each expected down-count and status follows from the cycle in which the strobe was taken. Channel tests run long enough after reset that negative down-count writes never cross below zero unintentionally.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH = 2;

  localparam logic [3:0] SEL_FREQ  = 4'd0;
  localparam logic [3:0] SEL_KCTL  = 4'd1;
  localparam logic [3:0] SEL_PCNT  = 4'd2;
  localparam logic [3:0] SEL_VCNT  = 4'd3;
  localparam logic [3:0] SEL_PCTL  = 4'd4;
  localparam logic [3:0] SEL_PCMP  = 4'd5;
  localparam logic [3:0] SEL_PDOWN = 4'd6;
  localparam logic [3:0] SEL_VCTL  = 4'd7;
  localparam logic [3:0] SEL_VCMP  = 4'd8;
  localparam logic [3:0] SEL_VDOWN = 4'd9;

  // strobes from the access control to the datapath
  typedef struct packed {
    logic              fault;
    logic              rdAcc;
    logic              wrFreq;
    logic              wrKctl;
    logic [NUM_CH-1:0] wrCtl;
    logic [NUM_CH-1:0] wrCmp;
    logic [NUM_CH-1:0] wrDown;
    logic [3:0]        sel;
  } strobe_t;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic [3:0] regSel,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [1:0] privLvl,
  input  logic [9:0] kctlLow,
  output strobe_t    strb
);
  logic access;
  logic user;
  logic allowed;

  assign access = rdEn | wrEn;
  assign user   = (privLvl == 2'd0);

  always_comb begin
    unique case (regSel)
      SEL_FREQ:                       allowed = !user || (!wrEn && (kctlLow[0] || kctlLow[1]));
      SEL_KCTL:                       allowed = !user;
      SEL_PCNT:                       allowed = !user || kctlLow[0];
      SEL_VCNT:                       allowed = !user || kctlLow[1];
      SEL_PCTL, SEL_PCMP, SEL_PDOWN:  allowed = !user || kctlLow[9];
      SEL_VCTL, SEL_VCMP, SEL_VDOWN:  allowed = !user || kctlLow[8];
      default:                        allowed = 1'b1;
    endcase
  end

  always_comb begin
    logic wrOk;
    wrOk         = wrEn && allowed;
    strb         = '0;
    strb.sel     = regSel;
    strb.fault   = access && !allowed;
    strb.rdAcc   = rdEn && allowed;
    strb.wrFreq  = wrOk && (regSel == SEL_FREQ);
    strb.wrKctl  = wrOk && (regSel == SEL_KCTL);
    strb.wrCtl   = {wrOk && (regSel == SEL_VCTL),  wrOk && (regSel == SEL_PCTL)};
    strb.wrCmp   = {wrOk && (regSel == SEL_VCMP),  wrOk && (regSel == SEL_PCMP)};
    strb.wrDown  = {wrOk && (regSel == SEL_VDOWN), wrOk && (regSel == SEL_PDOWN)};
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W  = 64,
  parameter int DOWN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrCtl,
  input  logic              wrCmp,
  input  logic              wrDown,
  output logic              enable,
  output logic              mask,
  output logic              status,
  output logic              irq,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [DOWN_W-1:0] downView
);
  logic [CNT_W-1:0] relTarget;
  logic [CNT_W-1:0] diff;

  // sign-extended relative write, added to the present count
  assign relTarget = cnt + CNT_W'($signed(wrData[DOWN_W-1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      mask   <= 1'b0;
      cmpVal <= '0;
    end else begin
      if (wrCtl) begin
        enable <= wrData[0];
        mask   <= wrData[1];
      end
      if (wrDown)     cmpVal <= relTarget;
      else if (wrCmp) cmpVal <= wrData;
    end
  end

  assign status   = enable && (cnt >= cmpVal);
  assign irq      = status && !mask;
  assign diff     = cmpVal - cnt;
  assign downView = diff[DOWN_W-1:0];
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int CNT_W    = 64,
  parameter int DOWN_W   = 32,
  parameter int KCTL_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strb,
  input  logic [CNT_W-1:0]              wrData,
  output logic [CNT_W-1:0]              rdData,
  output logic                          accFault,
  output logic [9:0]                    kctlLow,
  output logic [CNT_W-1:0]              cntNow,
  output logic [NUM_CH-1:0]             chanEn,
  output logic [NUM_CH-1:0]             chanMask,
  output logic [NUM_CH-1:0]             chanIrq,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmpVals
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] FREQ_RST = CNT_W'(1000000000 / PRESCALE);

  logic [CNT_W-1:0]              freqReg;
  logic [KCTL_W-1:0]             kctlReg;
  logic                          tick;
  logic [NUM_CH-1:0]             chanStat;
  logic [NUM_CH-1:0][DOWN_W-1:0] downViews;
  logic [CNT_W-1:0]              muxVal;

  generate
    if (PRESCALE > 1) begin : g_presc
      logic [PS_W-1:0] prescCnt;
      always_ff @(posedge clk) begin
        if (rst)                                  prescCnt <= '0;
        else if (prescCnt == PS_W'(PRESCALE - 1)) prescCnt <= '0;
        else                                      prescCnt <= prescCnt + 1'b1;
      end
      assign tick = (prescCnt == PS_W'(PRESCALE - 1));
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       cntNow <= '0;
    else if (tick) cntNow <= cntNow + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freqReg <= FREQ_RST;
      kctlReg <= '0;
    end else begin
      if (strb.wrFreq) freqReg <= wrData;
      if (strb.wrKctl) kctlReg <= wrData[KCTL_W-1:0];
    end
  end

  assign kctlLow = kctlReg[9:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dct_channel #(.CNT_W(CNT_W), .DOWN_W(DOWN_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cntNow),
      .wrData   (wrData),
      .wrCtl    (strb.wrCtl[ch]),
      .wrCmp    (strb.wrCmp[ch]),
      .wrDown   (strb.wrDown[ch]),
      .enable   (chanEn[ch]),
      .mask     (chanMask[ch]),
      .status   (chanStat[ch]),
      .irq      (chanIrq[ch]),
      .cmpVal   (cmpVals[ch]),
      .downView (downViews[ch])
    );
  end

  always_comb begin
    unique case (strb.sel)
      SEL_FREQ:  muxVal = freqReg;
      SEL_KCTL:  muxVal = CNT_W'(kctlReg);
      SEL_PCNT,
      SEL_VCNT:  muxVal = cntNow;
      SEL_PCTL:  muxVal = CNT_W'({chanStat[0], chanMask[0], chanEn[0]});
      SEL_PCMP:  muxVal = cmpVals[0];
      SEL_PDOWN: muxVal = CNT_W'(downViews[0]);
      SEL_VCTL:  muxVal = CNT_W'({chanStat[1], chanMask[1], chanEn[1]});
      SEL_VCMP:  muxVal = cmpVals[1];
      SEL_VDOWN: muxVal = CNT_W'(downViews[1]);
      default:   muxVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      accFault <= 1'b0;
    end else begin
      accFault <= strb.fault;
      if (strb.fault)      rdData <= '0;
      else if (strb.rdAcc) rdData <= muxVal;
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int CNT_W    = 64,
  parameter int DOWN_W   = 32,
  parameter int KCTL_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       regSel,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       privLvl,
  output logic [CNT_W-1:0] rdData,
  output logic             accFault,
  output logic             irqPhys,
  output logic             irqVirt
);
  strobe_t                      strb;
  logic [9:0]                   kctlLow;
  logic [CNT_W-1:0]             cntNow;
  logic [NUM_CH-1:0]            chanEn;
  logic [NUM_CH-1:0]            chanMask;
  logic [NUM_CH-1:0]            chanIrq;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVals;

  dct_ctrl u_ctrl (
    .regSel  (regSel),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .privLvl (privLvl),
    .kctlLow (kctlLow),
    .strb    (strb)
  );

  dct_datapath #(
    .PRESCALE (PRESCALE),
    .CNT_W    (CNT_W),
    .DOWN_W   (DOWN_W),
    .KCTL_W   (KCTL_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .accFault (accFault),
    .kctlLow  (kctlLow),
    .cntNow   (cntNow),
    .chanEn   (chanEn),
    .chanMask (chanMask),
    .chanIrq  (chanIrq),
    .cmpVals  (cmpVals)
  );

  assign irqPhys = chanIrq[0];
  assign irqVirt = chanIrq[1];
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic [3:0]             regSel,
  input logic                   rdEn,
  input logic                   wrEn,
  input logic [1:0]             privLvl,
  input logic [CNT_W-1:0]       rdData,
  input logic                   accFault,
  input logic                   irqPhys,
  input logic                   irqVirt,
  input logic [CNT_W-1:0]       cntNow,
  input logic [1:0]             chanEn,
  input logic [1:0]             chanMask,
  input logic [1:0][CNT_W-1:0]  cmpVals
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cntNow == $past(cntNow)) || (cntNow == $past(cntNow) + 1'b1));

  assert_phys_reached_R4: assert property (@(posedge clk) disable iff (rst)
    irqPhys |-> (cntNow >= cmpVals[0]));

  assert_virt_reached_R4: assert property (@(posedge clk) disable iff (rst)
    irqVirt |-> (cntNow >= cmpVals[1]));

  assert_phys_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irqPhys |-> (chanEn[0] && !chanMask[0]));

  assert_virt_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irqVirt |-> (chanEn[1] && !chanMask[1]));

  assert_kctl_user_R11: assert property (@(posedge clk) disable iff (rst)
    ((rdEn || wrEn) && privLvl == 2'd0 && regSel == 4'd1) |=> accFault);

  assert_fault_zero_R12: assert property (@(posedge clk) disable iff (rst)
    accFault |-> (rdData == '0));

  assert_fault_source_R12: assert property (@(posedge clk) disable iff (rst)
    accFault |-> ($past(privLvl) == 2'd0 && ($past(rdEn) || $past(wrEn))));
endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .regSel   (regSel),
  .rdEn     (rdEn),
  .wrEn     (wrEn),
  .privLvl  (privLvl),
  .rdData   (rdData),
  .accFault (accFault),
  .irqPhys  (irqPhys),
  .irqVirt  (irqVirt),
  .cntNow   (cntNow),
  .chanEn   (chanEn),
  .chanMask (chanMask),
  .cmpVals  (cmpVals)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PSC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  regSel = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [1:0]  privLvl = 2'd1;
  logic [63:0] rdData;
  logic        accFault;
  logic        irqPhys;
  logic        irqVirt;

  int          nChecks = 0;
  int          nFails = 0;
  logic [63:0] edgeCnt = '0;
  logic [63:0] cntAt;
  logic [63:0] rd;
  logic        flt;
  bit          done = 1'b0;

  dual_cmp_timer #(.PRESCALE(PSC)) u_dual_cmp_timer (
    .clk(clk), .rst(rst), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .privLvl(privLvl), .rdData(rdData), .accFault(accFault),
    .irqPhys(irqPhys), .irqVirt(irqVirt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst) edgeCnt <= edgeCnt + 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; called just after a falling edge, returns after the next one
  task automatic acc(logic [3:0] sel, bit r, bit w, logic [63:0] d, logic [1:0] pl);
    regSel = sel; rdEn = r; wrEn = w; wrData = d; privLvl = pl;
    cntAt = edgeCnt / PSC;
    @(posedge clk);
    @(negedge clk);
    rd = rdData; flt = accFault;
    rdEn = 1'b0; wrEn = 1'b0; privLvl = 2'd1;
  endtask

  task automatic rdk(logic [3:0] sel);  acc(sel, 1, 0, '0, 2'd1); endtask
  task automatic wrk(logic [3:0] sel, logic [63:0] d);  acc(sel, 0, 1, d, 2'd1); endtask
  task automatic idle(int n);  repeat (n) @(negedge clk); endtask

  task automatic t_reset;
    chk("R1 irqPhys", {63'b0, irqPhys}, 64'd0);
    chk("R1 irqVirt", {63'b0, irqVirt}, 64'd0);
    rdk(4'd0);  chk("R1 freq", rd, 64'd250000000);
    rdk(4'd1);  chk("R1 kctl", rd, 64'd0);
    rdk(4'd4);  chk("R1 pctl", rd, 64'd0);
    rdk(4'd7);  chk("R1 vctl", rd, 64'd0);
    rdk(4'd5);  chk("R1 pcmp", rd, 64'd0);
    rdk(4'd8);  chk("R1 vcmp", rd, 64'd0);
    rdk(4'd2);  chk("R1 counter", rd, cntAt);
    chk("R13 no fault", {63'b0, flt}, 64'd0);
  endtask

  task automatic t_counter;
    logic [63:0] e;
    rdk(4'd2);  chk("R2 phys counter", rd, cntAt);
    idle(37);
    rdk(4'd3);  chk("R2 virt counter", rd, cntAt);
    e = cntAt;
    rdk(4'd2);  chk("R2 counter rises", rd, cntAt);
    if (cntAt < e) chk("R2 monotonic", cntAt, e);
  endtask

  task automatic t_ctl;
    wrk(4'd4, 64'hFF);  rdk(4'd4);
    chk("R3 ctl keeps bits 1:0", rd, 64'd7);
    chk("R5 masked irq low", {63'b0, irqPhys}, 64'd0);
    wrk(4'd4, 64'h1);
    chk("R5 irq follows status", {63'b0, irqPhys}, 64'd1);
    wrk(4'd4, 64'h0);  rdk(4'd4);
    chk("R5 disabled status 0", rd, 64'd0);
    chk("R5 disabled irq low", {63'b0, irqPhys}, 64'd0);
    wrk(4'd4, 64'h4);  rdk(4'd4);
    chk("R3 status not writable", rd, 64'd0);
  endtask

  task automatic t_compare;
    logic [63:0] tgt;
    wrk(4'd5, 64'hFFFF_FFFF_FFFF_FFF0);
    wrk(4'd4, 64'h1);  rdk(4'd4);
    chk("R4 unsigned compare", rd, 64'd1);
    chk("R4 irq low before target", {63'b0, irqPhys}, 64'd0);
    wrk(4'd5, 64'd0);  tgt = cntAt + 3;
    wrk(4'd5, tgt);
    rdk(4'd4);
    chk("R4 status near target", rd, {61'b0, (cntAt >= tgt), 2'b01});
    idle(4 * PSC);
    rdk(4'd4);  chk("R4 status after target", rd, 64'd5);
    chk("R5 irq after target", {63'b0, irqPhys}, 64'd1);
    wrk(4'd4, 64'h0);
  endtask

  task automatic t_down;
    logic [63:0] x;
    logic [63:0] w;
    wrk(4'd8, 64'd0);  x = cntAt + 100;
    wrk(4'd8, x);
    rdk(4'd9);  chk("R6 down view", rd, {32'b0, 32'(x - cntAt)});
    wrk(4'd9, 64'h0000_0000_FFFF_FFFB);  w = cntAt - 5;
    rdk(4'd8);  chk("R7 negative relative write", rd, w);
    rdk(4'd9);  chk("R6 negative down view", rd, {32'b0, 32'(w - cntAt)});
    wrk(4'd7, 64'h1);
    chk("R5 virt irq", {63'b0, irqVirt}, 64'd1);
    wrk(4'd9, 64'hABCD_1234_7FFF_FFFF);  w = cntAt + 64'h7FFF_FFFF;
    rdk(4'd8);  chk("R7 upper data ignored", rd, w);
    chk("R4 virt before target", {63'b0, irqVirt}, 64'd0);
    wrk(4'd7, 64'h0);
  endtask

  task automatic t_freq;
    wrk(4'd0, 64'd12345);
    rdk(4'd0);  chk("R8 freq readback", rd, 64'd12345);
    idle(11);
    rdk(4'd2);  chk("R8 rate unchanged", rd, cntAt);
    wrk(4'd2, 64'd0);
    rdk(4'd2);  chk("R13 counter write ignored", rd, cntAt);
    rdk(4'd15); chk("R13 unmapped read", rd, 64'd0);
    chk("R13 unmapped no fault", {63'b0, flt}, 64'd0);
    acc(4'd12, 0, 1, 64'h55, 2'd0);
    chk("R13 unmapped write no fault", {63'b0, flt}, 64'd0);
  endtask

  task automatic t_priv;
    logic [63:0] cmpKeep;
    wrk(4'd1, 64'd0);
    wrk(4'd5, 64'h1234);
    acc(4'd2, 1, 0, '0, 2'd0); chk("R9 pcnt closed", {63'b0, flt}, 64'd1);
    chk("R12 fault data zero", rd, 64'd0);
    acc(4'd3, 1, 0, '0, 2'd0); chk("R9 vcnt closed", {63'b0, flt}, 64'd1);
    acc(4'd0, 1, 0, '0, 2'd0); chk("R11 freq closed", {63'b0, flt}, 64'd1);
    acc(4'd4, 1, 0, '0, 2'd0); chk("R10 pctl closed", {63'b0, flt}, 64'd1);
    acc(4'd5, 0, 1, 64'h9999, 2'd0); chk("R10 pcmp write closed", {63'b0, flt}, 64'd1);
    rdk(4'd5); cmpKeep = rd; chk("R12 state unchanged", cmpKeep, 64'h1234);
    wrk(4'd1, 64'h1);
    acc(4'd2, 1, 0, '0, 2'd0); chk("R9 pcnt open", rd, cntAt);
    chk("R9 pcnt open no fault", {63'b0, flt}, 64'd0);
    acc(4'd3, 1, 0, '0, 2'd0); chk("R9 vcnt bit 1", {63'b0, flt}, 64'd1);
    acc(4'd0, 1, 0, '0, 2'd0); chk("R11 freq open", rd, 64'd12345);
    wrk(4'd1, 64'h2);
    acc(4'd3, 1, 0, '0, 2'd0); chk("R9 vcnt open", rd, cntAt);
    acc(4'd2, 1, 0, '0, 2'd0); chk("R9 pcnt bit 0", {63'b0, flt}, 64'd1);
    acc(4'd0, 1, 0, '0, 2'd0); chk("R11 freq via bit 1", {63'b0, flt}, 64'd0);
    wrk(4'd1, 64'h200);
    acc(4'd5, 0, 1, 64'h777, 2'd0); chk("R10 phys open", {63'b0, flt}, 64'd0);
    acc(4'd5, 1, 0, '0, 2'd0); chk("R10 phys readback", rd, 64'h777);
    acc(4'd8, 1, 0, '0, 2'd0); chk("R10 virt needs bit 8", {63'b0, flt}, 64'd1);
    wrk(4'd1, 64'h100);
    acc(4'd7, 0, 1, 64'h2, 2'd0); chk("R10 virt open", {63'b0, flt}, 64'd0);
    acc(4'd6, 1, 0, '0, 2'd0); chk("R10 phys needs bit 9", {63'b0, flt}, 64'd1);
    acc(4'd1, 0, 1, 64'h3FF, 2'd0); chk("R11 kctl user write", {63'b0, flt}, 64'd1);
    rdk(4'd1); chk("R12 kctl unchanged", rd, 64'h100);
    wrk(4'd1, 64'h3);
    acc(4'd0, 0, 1, 64'd1, 2'd0); chk("R11 freq user write", {63'b0, flt}, 64'd1);
    rdk(4'd0); chk("R12 freq unchanged", rd, 64'd12345);
    acc(4'd0, 1, 1, 64'd42, 2'd1); chk("R13 read before write", rd, 64'd12345);
    rdk(4'd0); chk("R13 write taken", rd, 64'd42);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_counter();
        t_ctl();
        t_compare();
        t_down();
        t_freq();
        t_priv();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule